// File: doc/BRIEF.md
# Floating-Point Register Rename Status Table

This block keeps, for each architectural floating-point register, a committed value and the tag of the execution station that will write the register's next value. A tag of zero means the register is ready: its stored value is current and no producer is pending. When an instruction is dispatched, the front end reads its source registers through the lookup ports. Each lookup returns either a ready value or the producer tag the instruction must wait for. In the same cycle the front end points the destination register at the dispatching station through the rename port. Because later readers name the station rather than the register, write-after-read and write-after-write hazards disappear.

Completed results arrive on a shared result bus as a (tag, data) pair. A register takes the data and returns to ready only when its stored tag still equals the broadcast tag. An older producer whose register has since been re-tagged therefore writes nothing, and only the youngest writer's value survives. A lookup whose register is waiting on the tag being broadcast in that very cycle receives the bus data directly, so no cycle is lost.

Each register is a two-state machine. The states are `ENT_READY` (tag zero, value current) and `ENT_WAIT` (tag nonzero, value stale). The transitions are:
- `ENT_READY -> ENT_WAIT` on a rename.
- `ENT_WAIT -> ENT_WAIT` on a rename (re-tag), or on a broadcast with another tag (hold).
- `ENT_WAIT -> ENT_READY` on a broadcast with a matching tag and no rename of that register in the same cycle.
- `ENT_READY -> ENT_READY` when nothing happens.

Top module: `fp_rename_table`

## Requirements
- R1: After reset every register reads back with value 0, tag 0 and ready 1 on every lookup port.
- R2: A lookup of a ready register returns its stored value, tag 0 and ready 1 in the same cycle, combinationally from the index.
- R3: A rename (valid high, register index, nonzero tag) makes later lookups of that register return that tag with ready 0. A waiting register's value output keeps its last committed value. The rename tag must never be zero.
- R4: A broadcast whose tag equals a waiting register's stored tag writes the bus data into that register and sets its tag to 0, visible from the next cycle.
- R5: A broadcast whose tag differs from a waiting register's stored tag leaves that register's tag and value unchanged. This is the write-after-write case: after a second rename, an older producer's result is dropped.
- R6: When a rename and a matching broadcast hit the same register in one cycle, the rename wins: the new tag is kept and the stored value is not changed.
- R7: A lookup of a waiting register whose stored tag is on the result bus in the same cycle returns the bus data, tag 0 and ready 1.
- R8: A lookup in the same cycle as a rename of the same register returns the contents from before the rename.
- R9: A broadcast with tag 0 changes no register.
- R10: The lookup ports are independent: each returns the state of its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_idx_i | input | NUM_READ*REG_W (8) | Register index per lookup port, port p at bits [p*REG_W +: REG_W] |
| lk_val_o | output | NUM_READ*DATA_W (64) | Value per lookup port |
| lk_tag_o | output | NUM_READ*TAG_W (8) | Producer tag per lookup port, 0 when ready |
| lk_rdy_o | output | NUM_READ (2) | Ready flag per lookup port |
| ren_vld_i | input | 1 | Rename request |
| ren_idx_i | input | REG_W (4) | Destination register to rename |
| ren_tag_i | input | TAG_W (4) | Tag of the dispatching station, nonzero |
| bc_vld_i | input | 1 | Result bus valid |
| bc_tag_i | input | TAG_W (4) | Tag of the station driving the result bus |
| bc_data_i | input | DATA_W (32) | Result data |

## Verification
A rename and a result broadcast can land on the same register in one clock cycle. The bench provokes this by re-tagging a register while its current producer broadcasts, with a lookup of that register in the same cycle. The lookup must return the bus data, since the lookup sees the pre-rename state and the producer is broadcasting. In the following cycle the register must show the new tag and its old, unchanged value. A scoreboard computes every expected lookup from a small model built on the requirements. It also covers the neighbouring case in which an older producer broadcasts after its register has already been re-tagged.

// File: rtl/fp_rename_pkg.sv
package fp_rename_pkg;

    // Per-register occupancy state
    typedef enum logic {
        ENT_READY = 1'b0,   // tag zero, stored value current
        ENT_WAIT  = 1'b1    // tag names a pending producer
    } ent_state_e;

endpackage

// File: rtl/fp_rename_decode.sv
module fp_rename_decode #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ren_vld_i,
    input  logic [REG_W-1:0]    ren_idx_i,
    output logic [NUM_REGS-1:0] hit_o
);

    always_comb begin
        hit_o = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (ren_vld_i && (ren_idx_i == REG_W'(r))) begin
                hit_o[r] = 1'b1;
            end
        end
    end

    // R3: at most one register is re-tagged per cycle
    p_single_rename_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit_o));

    // R3: a valid rename always selects a register
    p_rename_selects_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ren_vld_i |-> ($countones(hit_o) == 1));

endmodule

// File: rtl/fp_rename_entry.sv
module fp_rename_entry
    import fp_rename_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ren_hit_i,
    input  logic [TAG_W-1:0]  ren_tag_i,
    input  logic              bc_vld_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_data_i,
    output ent_state_e        state_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] val_o
);

    ent_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              bc_match;

    // Only a waiting register can match; tag 0 never matches (R9)
    always_comb begin
        bc_match = (state_q == ENT_WAIT) && bc_vld_i && (bc_tag_i == tag_q);
    end

    // Next-state and next-data logic
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        val_d   = val_q;
        unique case (state_q)
            ENT_READY: begin
                if (ren_hit_i) begin
                    state_d = ENT_WAIT;
                    tag_d   = ren_tag_i;
                end
            end
            ENT_WAIT: begin
                if (ren_hit_i) begin
                    // rename wins over a same-cycle matching result (R6)
                    tag_d = ren_tag_i;
                end else if (bc_match) begin
                    state_d = ENT_READY;
                    tag_d   = '0;
                    val_d   = bc_data_i;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ENT_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Tag and value registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tag_q <= '0;
            val_q <= '0;
        end else begin
            tag_q <= tag_d;
            val_q <= val_d;
        end
    end

    // Outputs
    assign state_o = state_q;
    assign tag_o   = tag_q;
    assign val_o   = val_q;

    // R3: a rename lands its tag and puts the register in the waiting state
    p_rename_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ren_hit_i |=> (tag_q == $past(ren_tag_i)) && (state_q == ENT_WAIT));

    // R4: a matching result without a rename writes the value and frees the tag
    p_match_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bc_match && !ren_hit_i) |=> (state_q == ENT_READY) && (tag_q == '0)
                                     && (val_q == $past(bc_data_i)));

    // R5: a result for another tag leaves the register untouched
    p_mismatch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bc_vld_i && (bc_tag_i != tag_q) && !ren_hit_i) |=> $stable(tag_q) && $stable(val_q));

    // R6: rename and matching result in one cycle keep the stored value
    p_collide_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ren_hit_i && bc_match) |=> $stable(val_q));

    // R9: a tag-0 broadcast never touches a ready register
    p_zero_tag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ENT_READY && !ren_hit_i) |=> $stable(val_q) && (tag_q == '0));

endmodule

// File: rtl/fp_rename_read.sv
module fp_rename_read
    import fp_rename_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_W-1:0]  idx_i,
    input  ent_state_e        st_arr_i  [NUM_REGS],
    input  logic [TAG_W-1:0]  tag_arr_i [NUM_REGS],
    input  logic [DATA_W-1:0] val_arr_i [NUM_REGS],
    input  logic              bc_vld_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_data_i,
    output logic [DATA_W-1:0] val_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              rdy_o
);

    ent_state_e        sel_st;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_val;
    logic              bypass;

    always_comb begin
        sel_st  = st_arr_i[idx_i];
        sel_tag = tag_arr_i[idx_i];
        sel_val = val_arr_i[idx_i];
        bypass  = (sel_st == ENT_WAIT) && bc_vld_i && (bc_tag_i == sel_tag);
    end

    always_comb begin
        if (bypass) begin
            val_o = bc_data_i;
            tag_o = '0;
            rdy_o = 1'b1;
        end else begin
            val_o = sel_val;
            tag_o = sel_tag;
            rdy_o = (sel_st == ENT_READY);
        end
    end

    // R7: producer on the bus in the lookup cycle forwards its data
    p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bc_vld_i && (tag_arr_i[idx_i] != '0) && (bc_tag_i == tag_arr_i[idx_i]))
            |-> (rdy_o && (val_o == bc_data_i)));

    // R3: a waiting register with no result on the bus is not ready
    p_wait_not_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((tag_arr_i[idx_i] != '0) && !bc_vld_i) |-> (!rdy_o && (tag_o != '0)));

    // R2: ready flag and zero tag agree at the port
    p_ready_tag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_o |-> (tag_o == '0));

endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table
    import fp_rename_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int NUM_READ = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_READ*REG_W-1:0]    lk_idx_i,
    output logic [NUM_READ*DATA_W-1:0]   lk_val_o,
    output logic [NUM_READ*TAG_W-1:0]    lk_tag_o,
    output logic [NUM_READ-1:0]          lk_rdy_o,
    input  logic                         ren_vld_i,
    input  logic [REG_W-1:0]             ren_idx_i,
    input  logic [TAG_W-1:0]             ren_tag_i,
    input  logic                         bc_vld_i,
    input  logic [TAG_W-1:0]             bc_tag_i,
    input  logic [DATA_W-1:0]            bc_data_i
);

    logic [NUM_REGS-1:0] ren_hit;
    ent_state_e          st_arr  [NUM_REGS];
    logic [TAG_W-1:0]    tag_arr [NUM_REGS];
    logic [DATA_W-1:0]   val_arr [NUM_REGS];

    fp_rename_decode #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) dec_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ren_vld_i (ren_vld_i),
        .ren_idx_i (ren_idx_i),
        .hit_o     (ren_hit)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
        fp_rename_entry #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) ent_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ren_hit_i (ren_hit[r]),
            .ren_tag_i (ren_tag_i),
            .bc_vld_i  (bc_vld_i),
            .bc_tag_i  (bc_tag_i),
            .bc_data_i (bc_data_i),
            .state_o   (st_arr[r]),
            .tag_o     (tag_arr[r]),
            .val_o     (val_arr[r])
        );
    end

    for (genvar p = 0; p < NUM_READ; p++) begin : g_read
        fp_rename_read #(
            .NUM_REGS (NUM_REGS),
            .TAG_W    (TAG_W),
            .DATA_W   (DATA_W),
            .REG_W    (REG_W)
        ) rd_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .idx_i     (lk_idx_i[p*REG_W +: REG_W]),
            .st_arr_i  (st_arr),
            .tag_arr_i (tag_arr),
            .val_arr_i (val_arr),
            .bc_vld_i  (bc_vld_i),
            .bc_tag_i  (bc_tag_i),
            .bc_data_i (bc_data_i),
            .val_o     (lk_val_o[p*DATA_W +: DATA_W]),
            .tag_o     (lk_tag_o[p*TAG_W +: TAG_W]),
            .rdy_o     (lk_rdy_o[p])
        );
    end

    // R3: the rename port never carries the reserved tag zero
    p_ren_tag_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ren_vld_i |-> (ren_tag_i != '0));

    // R8: a lookup port that is not bypassed sees pre-rename contents
    p_pre_rename_view_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ren_vld_i && !bc_vld_i && (lk_idx_i[REG_W-1:0] == ren_idx_i))
            |-> (lk_tag_o[TAG_W-1:0] != ren_tag_i) || (tag_arr[ren_idx_i] == ren_tag_i));

endmodule

// File: tb/fp_rename_table_tb_top.sv
module fp_rename_table_tb_top;

    localparam int NR = 16;
    localparam int TW = 4;
    localparam int DW = 32;
    localparam int RW = 4;

    typedef struct {
        int          port;
        logic [DW-1:0] val;
        logic [TW-1:0] tag;
        logic        rdy;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*RW-1:0] lk_idx = '0;
    logic [2*DW-1:0] lk_val;
    logic [2*TW-1:0] lk_tag;
    logic [1:0]      lk_rdy;
    logic            ren_vld = 1'b0;
    logic [RW-1:0]   ren_idx = '0;
    logic [TW-1:0]   ren_tag = '0;
    logic            bc_vld = 1'b0;
    logic [TW-1:0]   bc_tag = '0;
    logic [DW-1:0]   bc_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];
    logic [TW-1:0] mtag [NR];
    logic [DW-1:0] mval [NR];

    always #5 clk = ~clk;

    fp_rename_table dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .lk_idx_i  (lk_idx),
        .lk_val_o  (lk_val),
        .lk_tag_o  (lk_tag),
        .lk_rdy_o  (lk_rdy),
        .ren_vld_i (ren_vld),
        .ren_idx_i (ren_idx),
        .ren_tag_i (ren_tag),
        .bc_vld_i  (bc_vld),
        .bc_tag_i  (bc_tag),
        .bc_data_i (bc_data)
    );

    // Driver: one cycle of stimulus; pushes expected lookups, then advances the model
    task automatic step(input int ra, input int rb,
                        input bit rv, input int rr, input int rt,
                        input bit bv, input int bt, input logic [DW-1:0] bd,
                        input string req);
        int idx [2];
        @(negedge clk);
        #1;
        idx[0] = ra; idx[1] = rb;
        lk_idx  = {RW'(rb), RW'(ra)};
        ren_vld = rv; ren_idx = RW'(rr); ren_tag = TW'(rt);
        bc_vld  = bv; bc_tag = TW'(bt); bc_data = bd;
        for (int p = 0; p < 2; p++) begin
            exp_t e;
            e.port = p;
            e.req  = req;
            if (mtag[idx[p]] != 0 && bv && mtag[idx[p]] == TW'(bt)) begin
                e.val = bd; e.tag = '0; e.rdy = 1'b1;
            end else begin
                e.val = mval[idx[p]]; e.tag = mtag[idx[p]]; e.rdy = (mtag[idx[p]] == 0);
            end
            q.push_back(e);
        end
        for (int r = 0; r < NR; r++) begin
            if (rv && r == rr) begin
                mtag[r] = TW'(rt);
            end else if (bv && mtag[r] != 0 && mtag[r] == TW'(bt)) begin
                mval[r] = bd;
                mtag[r] = '0;
            end
        end
    endtask

    // Monitor: compares lookup outputs against the queue, between edges
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (q.size() > 0) begin
                exp_t e;
                logic [DW-1:0] av;
                logic [TW-1:0] at;
                logic          ar;
                e  = q.pop_front();
                av = lk_val[e.port*DW +: DW];
                at = lk_tag[e.port*TW +: TW];
                ar = lk_rdy[e.port];
                checks++;
                if (av !== e.val || at !== e.tag || ar !== e.rdy) begin
                    errors++;
                    $display("FAIL %s port%0d: got val=%h tag=%0d rdy=%b, expected val=%h tag=%0d rdy=%b",
                             e.req, e.port, av, at, ar, e.val, e.tag, e.rdy);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            mtag[r] = '0;
            mval[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register ready and zero after reset
        for (int r = 0; r < NR; r += 2) begin
            step(r, r + 1, 0, 0, 0, 0, 0, '0, "R1 reset state");
        end

        // R3: rename r3 to tag 5; R8: same-cycle lookup sees old contents
        step(3, 0, 1, 3, 5, 0, 0, '0, "R8 lookup during rename");
        step(3, 3, 0, 0, 0, 0, 0, '0, "R3 renamed register waits");
        // R7: bypass while tag 5 broadcasts
        step(3, 1, 0, 0, 0, 1, 5, 32'hAAAA_0003, "R7 bypass on broadcast");
        // R4: value committed, tag freed
        step(3, 2, 0, 0, 0, 0, 0, '0, "R4 matching broadcast writes");

        // R5: write-after-write, older producer dropped
        step(4, 3, 1, 4, 1, 0, 0, '0, "R10 independent ports");
        step(4, 3, 1, 4, 2, 0, 0, '0, "R3 re-tag");
        step(4, 4, 0, 0, 0, 1, 1, 32'h1111_1111, "R5 stale producer no bypass");
        step(4, 5, 0, 0, 0, 0, 0, '0, "R5 stale producer ignored");
        step(4, 3, 0, 0, 0, 1, 2, 32'h2222_2222, "R7 youngest producer bypass");
        step(4, 3, 0, 0, 0, 0, 0, '0, "R4 youngest writer committed");

        // R6: rename and matching broadcast collide on r6
        step(6, 4, 1, 6, 3, 0, 0, '0, "R3 rename r6");
        step(6, 6, 1, 6, 7, 1, 3, 32'hDDDD_0006, "R6 collision cycle lookup");
        step(6, 0, 0, 0, 0, 0, 0, '0, "R6 rename wins value kept");
        step(6, 6, 0, 0, 0, 1, 7, 32'h7777_0006, "R7 bypass after collision");
        step(6, 4, 0, 0, 0, 0, 0, '0, "R4 after collision");

        // R8: rename a register holding a value, looked up in same cycle
        step(3, 4, 1, 3, 9, 0, 0, '0, "R8 pre-rename value");
        step(3, 4, 0, 0, 0, 0, 0, '0, "R3 waiting keeps old value");

        // R9: tag 0 broadcast is ignored
        step(0, 3, 0, 0, 0, 1, 0, 32'h1234_5678, "R9 tag zero broadcast");
        step(0, 15, 0, 0, 0, 0, 0, '0, "R9 tag zero no effect");
        step(3, 6, 0, 0, 0, 1, 9, 32'h9999_0003, "R7 bypass r3");
        step(3, 6, 0, 0, 0, 0, 0, '0, "R2 ready lookups");

        @(negedge clk);
        #1;
        ren_vld = 1'b0;
        bc_vld  = 1'b0;
        repeat (2) @(negedge clk);
        #5;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule